// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port

This block is the parallel I/O port of a small microcontroller core. The core writes an output latch through a data write strobe. It loads a direction register from its accumulator through a separate direction write strobe. Port reads return the live, synchronized pin levels rather than the latch contents, so a pin that is driven high but held low from outside reads as 0. Each pin connects to a pad through separate input, output value and output enable signals.

Around that core function, the block applies fixed per-pin rules. Pin 3 can never drive. An option setting can force pin 2 to stay undriven. Pins given to an alternate function read as 0. Pins 0, 1 and 3 carry weak pull-ups and a wake-on-change detector, each under one global enable. When pin 3 serves as the reset input, its pull-up is forced on and it takes no part in wake detection. The wake request is sticky: the core clears it by reading the port, and that read also takes a new reference snapshot.

Top module: `gpio_port6`

## Requirements
- R1: In the cycle after synchronous reset, the output latch holds 0, the direction register holds all ones, every `pad_oe` bit is 0 and `wake_req` is 0.
- R2: A cycle with `port_we` high loads `port_wdata` into the output latch at that clock edge. `pad_out` shows the latch, and the latch keeps its value while `port_we` is low, whatever `port_wdata` does.
- R3: A cycle with `dir_we` high loads `acc_data` into the direction register. For every pin other than 3, `pad_oe` is 1 when the pin's direction bit is 0 and 0 when it is 1.
- R4: `rd_data[5:0]` returns the `pad_in` levels after two synchronizing flops, not the output latch. `rd_data[7:6]` always reads 0.
- R5: `pad_oe[3]` is 0 for every direction register value.
- R6: For each pin with `alt_sel[i]` set to 1, `rd_data[i]` reads 0.
- R7: While `p2_force_in` is 1, `pad_oe[2]` is 0 whatever the direction bit of pin 2 holds.
- R8: `pad_pu` bits 0, 1 and 3 follow `pullup_en`, and bits 2, 4 and 5 are always 0. While `mclr_mode` is 1, `pad_pu[3]` is 1 regardless of `pullup_en`.
- R9: While `wake_en` is 1, any difference between the synchronized level of pin 0, 1 or 3 and the snapshot taken at the last port read sets `wake_req`. The flag stays set after the pin returns to its old level. Changes on pins 2, 4 and 5 have no effect, and neither do changes on pin 3 while `mclr_mode` is 1.
- R10: A cycle with `port_re` high clears `wake_req` at that edge and stores the current synchronized levels as the new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_we | input | 1 | Output latch write strobe |
| port_wdata | input | 6 | Data for the output latch |
| dir_we | input | 1 | Direction register write strobe |
| acc_data | input | 6 | Accumulator value loaded into the direction register |
| port_re | input | 1 | Port read strobe; clears wake and takes a snapshot |
| rd_data | output | 8 | Port read value |
| alt_sel | input | 6 | Per-pin alternate-function assignment |
| pullup_en | input | 1 | Global weak pull-up enable |
| wake_en | input | 1 | Global wake-on-change enable |
| mclr_mode | input | 1 | Pin 3 serves as the reset input |
| p2_force_in | input | 1 | Option setting that keeps pin 2 undriven |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables, 1 = drive |
| pad_pu | output | 6 | Weak pull-up enables |
| wake_req | output | 1 | Sticky wake request to the core |

## Verification
The bench drives a pin high through the latch while holding the pad low. A design that read back the latch would return 1 there. It clears every direction bit, so a design that let pin 3 or an overridden pin 2 drive would show those enable bits set. For wake detection, it changes an unmonitored pin, changes pin 3 while that pin serves as reset, and returns a monitored pin to its old level. A design with the wrong pin mask would raise a false wake, and a level-following flag would drop early. It also checks that wake is raised only after the two-flop synchronizer delay, and that a port read re-arms the detector.

// File: rtl/gpio_port6_pkg.sv
package gpio_port6_pkg;
    localparam int PORT_W = 6;
    localparam int BUS_W  = 8;
    localparam int SYNC_STAGES = 2;

    // pin roles fixed by the port's pinout
    localparam int RST_PIN = 3;
    localparam int OVR_PIN = 2;
    localparam logic [PORT_W-1:0] INPUT_ONLY_PINS = 6'b00_1000;
    localparam logic [PORT_W-1:0] FEATURE_PINS    = 6'b00_1011;
    localparam logic [PORT_W-1:0] RST_PIN_BIT     = 6'b00_1000;

    typedef struct packed {
        logic pullup_en;
        logic wake_en;
        logic mclr_mode;
        logic p2_force_in;
    } port_cfg_t;

    function automatic logic [PORT_W-1:0] wake_mask(port_cfg_t c);
        logic [PORT_W-1:0] m;
        m = c.wake_en ? FEATURE_PINS : '0;
        if (c.mclr_mode) m = m & ~RST_PIN_BIT;
        return m;
    endfunction

    function automatic logic [PORT_W-1:0] pullup_vec(port_cfg_t c);
        logic [PORT_W-1:0] p;
        p = c.pullup_en ? FEATURE_PINS : '0;
        if (c.mclr_mode) p = p | RST_PIN_BIT;
        return p;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int           W          = 6,
    parameter logic [W-1:0] INPUT_ONLY = '0,
    parameter int           OVR_IDX    = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         port_we,
    input  logic [W-1:0] port_wdata,
    input  logic         dir_we,
    input  logic [W-1:0] acc_data,
    input  logic         force_in,
    output logic [W-1:0] out_val,
    output logic [W-1:0] oe
);
    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '1;
        end else begin
            if (port_we) out_q <= port_wdata;
            if (dir_we)  dir_q <= acc_data;
        end
    end

    assign out_val = out_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (INPUT_ONLY[i]) begin : g_in_only
            assign oe[i] = 1'b0;
        end else if (i == OVR_IDX) begin : g_ovr
            assign oe[i] = ~dir_q[i] & ~force_in;
        end else begin : g_plain
            assign oe[i] = ~dir_q[i];
        end
    end

    AST_DIR_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (oe == '0));                                      // R1
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!port_we && !$past(rst)) |=> (out_val == $past(out_val)));       // R2
    AST_P2_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        force_in |-> !oe[OVR_IDX]);                                       // R7
endmodule

// File: rtl/gpio_wake_det.sv
module gpio_wake_det #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mask,
    input  logic         rd_strobe,
    output logic         wake
);
    logic [W-1:0] snap_q;
    logic         req_q;
    logic         diff;

    assign diff = |((lvl ^ snap_q) & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            req_q  <= 1'b0;
        end else if (rd_strobe) begin
            snap_q <= lvl;
            req_q  <= 1'b0;
        end else if (diff) begin
            req_q  <= 1'b1;
        end
    end

    assign wake = req_q;

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wake && !rd_strobe) |=> wake);                                   // R9
    AST_WAKE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !wake);                                             // R10
endmodule

// File: rtl/gpio_port6.sv
module gpio_port6
    import gpio_port6_pkg::*;
#(
    parameter int PINS = PORT_W,
    parameter int DW   = BUS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            port_we,
    input  logic [PINS-1:0] port_wdata,
    input  logic            dir_we,
    input  logic [PINS-1:0] acc_data,
    input  logic            port_re,
    output logic [DW-1:0]   rd_data,
    input  logic [PINS-1:0] alt_sel,
    input  logic            pullup_en,
    input  logic            wake_en,
    input  logic            mclr_mode,
    input  logic            p2_force_in,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pu,
    output logic            wake_req
);
    localparam int PAD_W = DW - PINS;

    port_cfg_t       cfg;
    logic [PINS-1:0] lvl_sync;
    logic [PINS-1:0] wmask;

    assign cfg = '{pullup_en: pullup_en, wake_en: wake_en,
                   mclr_mode: mclr_mode, p2_force_in: p2_force_in};

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl_sync)
    );

    gpio_port_regs #(.W(PINS), .INPUT_ONLY(INPUT_ONLY_PINS), .OVR_IDX(OVR_PIN)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .port_we    (port_we),
        .port_wdata (port_wdata),
        .dir_we     (dir_we),
        .acc_data   (acc_data),
        .force_in   (cfg.p2_force_in),
        .out_val    (pad_out),
        .oe         (pad_oe)
    );

    assign wmask = wake_mask(cfg);

    gpio_wake_det #(.W(PINS)) u_wake (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl_sync),
        .mask      (wmask),
        .rd_strobe (port_re),
        .wake      (wake_req)
    );

    assign pad_pu  = pullup_vec(cfg);
    assign rd_data = {{PAD_W{1'b0}}, lvl_sync & ~alt_sel};

    AST_ALT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((rd_data[PINS-1:0] & alt_sel) == '0));                           // R6
endmodule

// File: tb/gpio_port6_tb.sv
`timescale 1ns/1ps
module gpio_port6_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_we = 0, dir_we = 0, port_re = 0;
    logic [5:0] port_wdata = 0, acc_data = 0, alt_sel = 0, pad_in = 0;
    logic       pullup_en = 0, wake_en = 0, mclr_mode = 0, p2_force_in = 0;
    logic [7:0] rd_data;
    logic [5:0] pad_out, pad_oe, pad_pu;
    logic       wake_req;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    gpio_port6 u_dut (
        .clk(clk), .rst(rst), .port_we(port_we), .port_wdata(port_wdata),
        .dir_we(dir_we), .acc_data(acc_data), .port_re(port_re),
        .rd_data(rd_data), .alt_sel(alt_sel), .pullup_en(pullup_en),
        .wake_en(wake_en), .mclr_mode(mclr_mode), .p2_force_in(p2_force_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .wake_req(wake_req)
    );

    // {pad_in, alt_sel, expected rd_data}
    localparam logic [19:0] VEC [8] = '{
        {6'h3F, 6'h00, 8'h3F}, {6'h00, 6'h00, 8'h00},
        {6'h15, 6'h00, 8'h15}, {6'h2A, 6'h00, 8'h2A},
        {6'h3F, 6'h05, 8'h3A}, {6'h3F, 6'h30, 8'h0F},
        {6'h0C, 6'h0C, 8'h00}, {6'h21, 6'h3E, 8'h01}
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle(); repeat (3) @(negedge clk); endtask

    task automatic wr_port(logic [5:0] v);
        port_wdata = v; port_we = 1; @(negedge clk); port_we = 0;
    endtask

    task automatic wr_dir(logic [5:0] v);
        acc_data = v; dir_we = 1; @(negedge clk); dir_we = 0;
    endtask

    task automatic rd_port();
        port_re = 1; @(negedge clk); port_re = 0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", {2'b0, pad_oe}, 8'h00);
        chk("R1 latch", {2'b0, pad_out}, 8'h00);
        chk("R1 wake", {7'b0, wake_req}, 8'h00);

        // R4 / R6 vector walk
        foreach (VEC[k]) begin
            pad_in = VEC[k][19:14]; alt_sel = VEC[k][13:8];
            settle();
            chk(k < 4 ? "R4 read" : "R6 alt read", rd_data, VEC[k][7:0]);
        end
        alt_sel = 0;

        // R4 synchronizer latency: two edges
        pad_in = 6'h00; settle();
        pad_in = 6'h01; @(negedge clk);
        chk("R4 one edge", rd_data, 8'h00);
        @(negedge clk);
        chk("R4 two edges", rd_data, 8'h01);

        // R2 latch write and hold
        wr_port(6'h2D);
        chk("R2 write", {2'b0, pad_out}, 8'h2D);
        port_wdata = 6'h12; repeat (2) @(negedge clk);
        chk("R2 hold", {2'b0, pad_out}, 8'h2D);

        // R3 / R5 direction
        wr_dir(6'h00);
        chk("R3 all out, R5 pin3", {2'b0, pad_oe}, 8'h37);
        wr_dir(6'h15);
        chk("R3 mixed", {2'b0, pad_oe}, 8'h22);
        wr_dir(6'h00);
        // R4: latch drives high, pad held low -> reads pad
        wr_port(6'h3F); pad_in = 6'h00; settle();
        chk("R4 pin not latch", rd_data, 8'h00);

        // R7 pin2 override
        p2_force_in = 1; #1;
        chk("R7 override", {2'b0, pad_oe}, 8'h33);
        p2_force_in = 0; #1;
        chk("R7 released", {2'b0, pad_oe}, 8'h37);
        wr_dir(6'h3F);

        // R8 pull-ups
        pullup_en = 1; #1; chk("R8 global", {2'b0, pad_pu}, 8'h0B);
        pullup_en = 0; mclr_mode = 1; #1; chk("R8 reset pin", {2'b0, pad_pu}, 8'h08);
        mclr_mode = 0; #1; chk("R8 off", {2'b0, pad_pu}, 8'h00);

        // R9 / R10 wake-on-change
        wake_en = 1; pad_in = 6'h00; settle(); rd_port();
        chk("R10 cleared", {7'b0, wake_req}, 8'h00);
        pad_in = 6'h34; repeat (4) @(negedge clk);
        chk("R9 unmonitored pins", {7'b0, wake_req}, 8'h00);
        pad_in = 6'h00; settle(); rd_port();
        pad_in = 6'h02; @(negedge clk); @(negedge clk);
        chk("R9 not yet", {7'b0, wake_req}, 8'h00);
        @(negedge clk);
        chk("R9 pin1 wake", {7'b0, wake_req}, 8'h01);
        pad_in = 6'h00; repeat (4) @(negedge clk);
        chk("R9 sticky", {7'b0, wake_req}, 8'h01);
        rd_port();
        chk("R10 read clears", {7'b0, wake_req}, 8'h00);
        mclr_mode = 1; pad_in = 6'h08; repeat (4) @(negedge clk);
        chk("R9 reset pin excluded", {7'b0, wake_req}, 8'h00);
        mclr_mode = 0; @(negedge clk);
        chk("R9 pin3 wake", {7'b0, wake_req}, 8'h01);
        rd_port(); repeat (3) @(negedge clk);
        chk("R10 new snapshot", {7'b0, wake_req}, 8'h00);
        wake_en = 0; pad_in = 6'h00; repeat (4) @(negedge clk);
        chk("R9 disabled", {7'b0, wake_req}, 8'h00);

        // R1 reset again restores direction
        wr_dir(6'h00);
        rst = 1; @(negedge clk); rst = 0; @(negedge clk);
        chk("R1 re-reset oe", {2'b0, pad_oe}, 8'h00);
        chk("R1 re-reset latch", {2'b0, pad_out}, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule